// File: doc/BRIEF.md
# Selectable Sequence Counter Bus Arbiter

This block arbitrates a shared synchronous bus among a parameterised number of devices in dynamic time-division fashion. Every device has one request bit. At the start of each round the arbiter latches the request vector and then hands out one timeslot per clock to each latched requester, lowest device ID first. Devices that were not requesting at the round start get no slot, so no bus cycle is spent on them. When the last latched requester has had its slot, the next round starts on the following edge from whatever is requesting then.

The core is a counter whose next value is picked by a set of tracking cells, one per count value. Value 0 is the rest state. Value i+1 stands for device i. Each non-rest cell holds a latched select bit and a flag that marks its value as already served in the current round. A lowest-index picker chooses the next count from the cells that are selected and not yet served. When no cell is left, an internal restart clears every flag and latches a fresh request vector. If nothing is requesting at that point, the counter is not enabled and parks at the rest value. The grant leaves the block each cycle as a plain control output: a device ID and a valid flag. The bus owner cannot push back on a grant, so there is no ready input, and a slot that its owner does not use is simply lost.

Top module: `ssc_arbiter`

## Requirements
- R1: After reset, count_o is 0 and grant_valid_o is 0.
- R2: While req_i is all zeros at a round boundary, count_o stays 0 and grant_valid_o stays 0 on every cycle.
- R3: count_o value 0 means no grant. A value k from 1 to N_DEV grants device k-1: grant_valid_o is 1 and grant_id_o equals k-1. grant_id_o is 0 whenever grant_valid_o is 0.
- R4: Within a round, the latched requesters are granted on consecutive cycles in strictly ascending device ID order.
- R5: Each device latched at the start of a round is granted exactly once in that round.
- R6: A device whose request bit was 0 when the round started is never granted during that round.
- R7: req_i is sampled only on the edge that starts a round. Changes during a round (new requests, dropped requests) take effect only in the next round. A device that drops its request mid-round is still granted in that round.
- R8: On the edge after the last latched requester's slot, a new round starts from the current req_i with no idle cycle, provided req_i is non-zero.
- R9: With exactly one device requesting, that device is granted on every cycle.
- R10: From the rest state, a request present before a rising edge produces a grant visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_DEV | One pending-request bit per device; bit i belongs to device i |
| count_o | output | clog2(N_DEV+1) | Raw sequence counter: 0 = rest, k = device k-1 |
| grant_id_o | output | clog2(N_DEV+1) | ID of the device that owns the current slot |
| grant_valid_o | output | 1 | High when a device owns the current slot |

## Verification
The hardest situation to reach from the ports is a request vector that changes partway through a round. Here the latched selection differs from the live inputs. A device that dropped out must still get its slot, and a device that joined must still wait. The bench starts a round from rest with one pattern. Right after the first grant it swaps in a disjoint pattern that contains a lower ID than the remaining latched one. This makes the arbiter finish the old round before the newcomer is served. A second case drops all requests mid-round and expects the remaining latched grant and then a return to rest.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  function automatic int cnt_width(input int n_dev);
    return (n_dev < 1) ? 1 : $clog2(n_dev + 1);
  endfunction
endpackage

// File: rtl/ssc_lowest.sv
module ssc_lowest #(
  parameter int W  = 5,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = IW'(k);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/ssc_cell.sv
module ssc_cell #(
  parameter int ID = 1,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          sel_i,
  input  logic [CW-1:0] count_i,
  output logic          en_o
);
  logic sel_q;
  logic served_q;
  logic served_now;

  assign served_now = served_q | (count_i == CW'(ID));
  assign en_o       = sel_q & ~served_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      served_q <= 1'b0;
    end else if (restart_i) begin
      sel_q    <= sel_i;
      served_q <= 1'b0;
    end else begin
      served_q <= served_now;
    end
  end
endmodule

// File: rtl/ssc_arbiter.sv
module ssc_arbiter #(
  parameter int N_DEV = 4,
  localparam int CW = ssc_pkg::cnt_width(N_DEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] req_i,
  output logic [CW-1:0]    count_o,
  output logic [CW-1:0]    grant_id_o,
  output logic             grant_valid_o
);
  localparam int NCELL = N_DEV + 1;

  logic [CW-1:0]    cnt_q;
  logic [NCELL-1:0] cell_en;
  logic [NCELL-1:0] fresh_sel;
  logic [CW-1:0]    pend_idx;
  logic [CW-1:0]    fresh_idx;
  logic             pend_any;
  logic             fresh_any;
  logic             restart;
  logic             cnt_en;

  assign fresh_sel = {req_i, 1'b0};
  assign restart   = ~pend_any;

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    if (k == 0) begin : g_rest
      assign cell_en[k] = 1'b0;
    end else begin : g_track
      ssc_cell #(.ID(k), .CW(CW)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .sel_i    (fresh_sel[k]),
        .count_i  (cnt_q),
        .en_o     (cell_en[k])
      );
    end
  end

  ssc_lowest #(.W(NCELL), .IW(CW)) u_pick_pend (
    .vec_i(cell_en),
    .idx_o(pend_idx),
    .any_o(pend_any)
  );

  ssc_lowest #(.W(NCELL), .IW(CW)) u_pick_fresh (
    .vec_i(fresh_sel),
    .idx_o(fresh_idx),
    .any_o(fresh_any)
  );

  assign cnt_en = pend_any | fresh_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= pend_any ? pend_idx : fresh_idx;
    end else begin
      cnt_q <= '0;
    end
  end

  assign count_o       = cnt_q;
  assign grant_valid_o = (cnt_q != '0);
  assign grant_id_o    = grant_valid_o ? (cnt_q - CW'(1)) : '0;
endmodule

// File: rtl/ssc_arbiter_chk.sv
module ssc_arbiter_chk #(
  parameter int N_DEV = 4,
  parameter int CW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] req_i,
  input logic [CW-1:0]    count_o,
  input logic [CW-1:0]    grant_id_o,
  input logic             grant_valid_o
);
  logic [N_DEV-1:0] id_mask;
  assign id_mask = N_DEV'(1) << grant_id_o;

  p_rest_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count_o == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0 && !grant_valid_o) |=> !grant_valid_o);

  p_id_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> (grant_id_o < CW'(N_DEV)));

  p_first_grant_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !$past(grant_valid_o)) |-> (($past(req_i) & id_mask) != '0));
endmodule

bind ssc_arbiter ssc_arbiter_chk #(.N_DEV(N_DEV), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .count_o      (count_o),
  .grant_id_o   (grant_id_o),
  .grant_valid_o(grant_valid_o)
);

// File: tb/ssc_arbiter_bench.sv
module ssc_arbiter_bench;
  localparam int N_DEV = 4;
  localparam int CW = ssc_pkg::cnt_width(N_DEV);
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_DEV-1:0] req = '0;
  logic [CW-1:0]    count;
  logic [CW-1:0]    gid;
  logic             gvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ssc_arbiter #(.N_DEV(N_DEV)) u_ssc_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .count_o      (count),
    .grant_id_o   (gid),
    .grant_valid_o(gvalid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_grant(input int dev, input string tag);
    chk(gvalid == 1'b1, {tag, " valid"}, int'(gvalid), 1);
    chk(int'(gid) == dev, {tag, " id"}, int'(gid), dev);
    chk(int'(count) == dev + 1, {tag, " R3 count"}, int'(count), dev + 1);
  endtask

  task automatic expect_rest(input string tag);
    chk(gvalid == 1'b0, {tag, " valid"}, int'(gvalid), 0);
    chk(count == '0, {tag, " count"}, int'(count), 0);
    chk(gid == '0, {tag, " R3 id"}, int'(gid), 0);
  endtask

  task automatic go_idle();
    req = '0;
    repeat (N_DEV + 2) tick();
    expect_rest("R2 idle");
  endtask

  // one full round with a constant mask, starting at a round boundary
  task automatic run_round(input logic [N_DEV-1:0] mask, input string tag);
    logic [N_DEV-1:0] seen;
    seen = '0;
    req = mask;
    for (int i = 0; i < N_DEV; i++) begin
      if (mask[i]) begin
        tick();
        expect_grant(i, {tag, " R4 order"});
        if (gvalid && int'(gid) < N_DEV) seen[gid[$clog2(N_DEV)-1:0]] = 1'b1;
      end
    end
    chk(seen == mask, {tag, " R5/R6 served set"}, int'(seen), int'(mask));
  endtask

  task automatic t_reset();
    expect_rest("R1 in reset");
    rst_n = 1'b1;
    tick();
    expect_rest("R1 after reset");
  endtask

  task automatic t_idle();
    req = '0;
    for (int i = 0; i < 5; i++) begin
      tick();
      expect_rest("R2 zero requests");
    end
  endtask

  task automatic t_worked();
    go_idle();
    req = 4'b1101;
    tick();
    expect_grant(0, "R10 first slot");
    tick();
    expect_grant(2, "R4 skip device 1");
    tick();
    expect_grant(3, "R4 third slot");
    tick();
    expect_grant(0, "R8 back-to-back round");
    tick();
    expect_grant(2, "R8 second round");
    tick();
    expect_grant(3, "R8 second round end");
  endtask

  task automatic t_patterns();
    go_idle();
    run_round(4'b1111, "all");
    run_round(4'b1111, "all R8 repeat");
    go_idle();
    run_round(4'b1000, "top only");
    go_idle();
    run_round(4'b0110, "middle");
    run_round(4'b0110, "middle R8 repeat");
    go_idle();
    run_round(4'b1001, "ends");
  endtask

  task automatic t_single();
    go_idle();
    req = 4'b0010;
    for (int i = 0; i < 6; i++) begin
      tick();
      expect_grant(1, "R9 single requester");
    end
  endtask

  task automatic t_midround();
    go_idle();
    req = 4'b0101;
    tick();
    expect_grant(0, "R7 start");
    req = 4'b1010;
    tick();
    expect_grant(2, "R7 dropped device still served, R6 newcomer waits");
    tick();
    expect_grant(1, "R7 R8 newcomer next round");
    tick();
    expect_grant(3, "R7 newcomer round");
    go_idle();
    req = 4'b0110;
    tick();
    expect_grant(1, "R7 drop-all start");
    req = '0;
    tick();
    expect_grant(2, "R7 latched slot after drop");
    tick();
    expect_rest("R2 rest after drop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_worked();
    t_patterns();
    t_single();
    t_midround();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule